// File: doc/BRIEF.md
# Linked Output Compare Generator

This block is one timer channel that drives a single output pin. It compares a free-running 16-bit time base against a match time that it computes itself. When the two are equal it applies a selected action to the pin: drive high, drive low, or invert. The match time is always formed with modular addition, so a schedule that crosses the wrap of the time base behaves the same as one that does not.

There are three ways to start the channel. In immediate mode a host strobe starts a pulse at once, and the pulse lasts a programmed number of time-base ticks. In delayed mode a host strobe arms one edge at a programmed delay after a reference time that the host supplies. In continuous mode the host plays no part. A link strobe from a neighbouring channel starts a serial multiply of a reference period by an 8-bit fractional ratio. Once the multiply has finished, the pin toggles every OFFSET ticks, which gives a square wave with equal high and low times. A host halt returns the pin to a programmable idle level and drops any scheduled match.

Top module: `link_cmp_gen`

## Requirements
- R1: While `rst` is high the pin takes the level on `idle_i`. The channel leaves reset idle, with no match armed.
- R2: Immediate mode (`mode_i`=0). A `go_i` sampled at edge E drives the pin to the lead level at E. The match action is applied at edge E+D, where D is `delay_i`, and a `delay_i` of 0 counts as 1. The pin then stays put. The lead level is low for action high, high for action low, and the inverse of the present pin for toggle.
- R3: Delayed mode (`mode_i`=1). A `go_i` leaves the pin unchanged. The action is applied once, on the clock edge at which `tbase_i` equals `ref_i`+`delay_i` (mod 2^16). After that the pin holds.
- R4: The match action code `act_i` is 0 for drive high, 1 for drive low, and 2 or 3 for invert.
- R5: Continuous mode (`mode_i`=2 or 3) starts only on `link_i`, and `go_i` in this mode has no effect. `link_i` in mode 0 or 1 has no effect.
- R6: OFFSET is floor(`period_i` × `ratio_i` / 256), with a result of 0 replaced by 1.
- R7: With a link sampled at edge E, the pin first toggles at edge E+9+OFFSET. It then toggles every OFFSET edges, whatever the value of `act_i`.
- R8: All match times wrap modulo 2^16, so a schedule that crosses the time-base wrap keeps its exact timing.
- R9: A `halt_i` sampled at an edge sets the pin to `idle_i` at that edge and cancels any pending match. A halt wins over a `go_i` or `link_i` at the same edge.
- R10: While a one-shot is pending or a continuous wave is running, further `go_i` and `link_i` strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | 16 | Free-running time base |
| go_i | input | 1 | Host start strobe (modes 0 and 1) |
| halt_i | input | 1 | Host stop strobe |
| link_i | input | 1 | Link strobe from another channel (continuous start) |
| mode_i | input | 2 | 0 immediate, 1 delayed, 2 or 3 continuous |
| act_i | input | 2 | Match action: 0 high, 1 low, 2 or 3 invert |
| idle_i | input | 1 | Idle pin level used at reset and on halt |
| delay_i | input | 16 | Pulse length or delay in ticks |
| ref_i | input | 16 | Reference time for delayed mode |
| period_i | input | 16 | Reference period for continuous mode |
| ratio_i | input | 8 | Ratio as an unsigned fraction of 256 |
| pin_o | output | 1 | Output pin |

## Verification
Immediate and delayed starts are swept over every action code and a spread of delays that includes zero, so that lead and final levels and an off-by-one in the match position can be told apart. Continuous mode is swept over a grid of period and ratio values. The grid includes ratios 0 and 1, which force the clamp, and large products, which separate a correct fractional scaling from a shifted or truncated one. A second pass starts each mode just before the time base wraps, to expose any non-modular compare. Strobes are also given in the wrong mode, while the channel is busy, and in the same cycle as a halt, and the pin is watched over the cycles in which a wrongly accepted strobe would have shown.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CALC,
        ST_RUN
    } lcg_state_e;

    typedef enum logic [2:0] {
        PIN_HOLD,
        PIN_IDLE,
        PIN_HIGH,
        PIN_LOW,
        PIN_FLIP
    } pin_op_e;

    localparam logic [1:0] ACT_HIGH = 2'd0;
    localparam logic [1:0] ACT_LOW  = 2'd1;
    localparam logic [1:0] MODE_IMM = 2'd0;

    typedef struct packed {
        logic load;
        logic adv;
        logic clear;
    } cmp_ctl_t;

    function automatic pin_op_e match_op(input logic [1:0] act);
        case (act)
            ACT_HIGH: match_op = PIN_HIGH;
            ACT_LOW:  match_op = PIN_LOW;
            default:  match_op = PIN_FLIP;
        endcase
    endfunction

    function automatic pin_op_e lead_op(input logic [1:0] act);
        case (act)
            ACT_HIGH: lead_op = PIN_LOW;
            ACT_LOW:  lead_op = PIN_HIGH;
            default:  lead_op = PIN_FLIP;
        endcase
    endfunction

endpackage

// File: rtl/lcg_ratio_mul.sv
module lcg_ratio_mul #(
    parameter int TW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [TW-1:0] base_i,
    input  logic [RW-1:0] ratio_i,
    output logic          done_o,
    output logic [TW-1:0] scaled_o
);
    localparam int PW = TW + RW;
    localparam int CW = $clog2(RW + 1);

    logic [PW-1:0] acc_q;
    logic [PW-1:0] mcand_q;
    logic [RW-1:0] mplr_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // One shift-add step per cycle, least significant ratio bit first
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (start_i) begin
            acc_q   <= '0;
            mcand_q <= PW'(base_i);
            mplr_q  <= ratio_i;
            cnt_q   <= CW'(RW);
            done_q  <= 1'b0;
        end else if (cnt_q != '0) begin
            if (mplr_q[0]) begin
                acc_q <= acc_q + mcand_q;
            end
            mcand_q <= mcand_q << 1;
            mplr_q  <= mplr_q >> 1;
            cnt_q   <= cnt_q - CW'(1);
            done_q  <= (cnt_q == CW'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o   = done_q;
    assign scaled_o = acc_q[PW-1:RW];

    // R7
    mul_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_q == '0));

endmodule

// File: rtl/lcg_match_unit.sv
module lcg_match_unit
    import lcg_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tbase_i,
    input  cmp_ctl_t      ctl_i,
    input  logic [TW-1:0] load_val_i,
    input  logic [TW-1:0] step_i,
    output logic          fire_o
);
    logic [TW-1:0] match_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            armed_q <= 1'b0;
        end else if (ctl_i.clear) begin
            armed_q <= 1'b0;
        end else if (ctl_i.load) begin
            match_q <= load_val_i;
            armed_q <= 1'b1;
        end else if (ctl_i.adv) begin
            match_q <= match_q + step_i;
        end
    end

    assign fire_o = armed_q && (tbase_i == match_q);

    // R3
    cmp_retire_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (!armed_q || match_q != $past(match_q)));

endmodule

// File: rtl/lcg_pin_drv.sv
module lcg_pin_drv
    import lcg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    idle_i,
    input  pin_op_e op_i,
    output logic    pin_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= idle_i;
        end else begin
            case (op_i)
                PIN_IDLE: pin_q <= idle_i;
                PIN_HIGH: pin_q <= 1'b1;
                PIN_LOW:  pin_q <= 1'b0;
                PIN_FLIP: pin_q <= ~pin_q;
                default:  pin_q <= pin_q;
            endcase
        end
    end

    assign pin_o = pin_q;

    // R4
    pin_level_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == PIN_HIGH) |=> pin_o);

endmodule

// File: rtl/link_cmp_gen.sv
module link_cmp_gen
    import lcg_pkg::*;
#(
    parameter int TW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tbase_i,
    input  logic          go_i,
    input  logic          halt_i,
    input  logic          link_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    act_i,
    input  logic          idle_i,
    input  logic [TW-1:0] delay_i,
    input  logic [TW-1:0] ref_i,
    input  logic [TW-1:0] period_i,
    input  logic [RW-1:0] ratio_i,
    output logic          pin_o
);
    lcg_state_e    st_q, st_d;
    logic [1:0]    act_q, act_d;
    logic [TW-1:0] off_q, off_d;

    pin_op_e       op;
    cmp_ctl_t      ctl;
    logic [TW-1:0] ld_val;
    logic          mul_go;
    logic          mul_done;
    logic [TW-1:0] scaled;
    logic          fire;

    logic [TW-1:0] delay_eff;
    logic [TW-1:0] off_eff;

    assign delay_eff = (delay_i == '0) ? TW'(1) : delay_i;
    assign off_eff   = (scaled == '0) ? TW'(1) : scaled;

    always_comb begin
        st_d   = st_q;
        act_d  = act_q;
        off_d  = off_q;
        op     = PIN_HOLD;
        ctl    = '0;
        ld_val = '0;
        mul_go = 1'b0;
        if (halt_i) begin
            op        = PIN_IDLE;
            ctl.clear = 1'b1;
            st_d      = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go_i && !mode_i[1]) begin
                        act_d    = act_i;
                        ctl.load = 1'b1;
                        st_d     = ST_WAIT;
                        if (mode_i == MODE_IMM) begin
                            ld_val = tbase_i + delay_eff;
                            op     = lead_op(act_i);
                        end else begin
                            ld_val = ref_i + delay_i;
                        end
                    end else if (link_i && mode_i[1]) begin
                        mul_go = 1'b1;
                        st_d   = ST_CALC;
                    end
                end
                ST_WAIT: begin
                    if (fire) begin
                        op        = match_op(act_q);
                        ctl.clear = 1'b1;
                        st_d      = ST_IDLE;
                    end
                end
                ST_CALC: begin
                    if (mul_done) begin
                        ctl.load = 1'b1;
                        ld_val   = tbase_i + off_eff;
                        off_d    = off_eff;
                        st_d     = ST_RUN;
                    end
                end
                default: begin
                    if (fire) begin
                        op      = PIN_FLIP;
                        ctl.adv = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            act_q <= '0;
            off_q <= TW'(1);
        end else begin
            st_q  <= st_d;
            act_q <= act_d;
            off_q <= off_d;
        end
    end

    lcg_ratio_mul #(.TW(TW), .RW(RW)) mul_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (mul_go),
        .base_i   (period_i),
        .ratio_i  (ratio_i),
        .done_o   (mul_done),
        .scaled_o (scaled)
    );

    lcg_match_unit #(.TW(TW)) cmp_i (
        .clk        (clk),
        .rst        (rst),
        .tbase_i    (tbase_i),
        .ctl_i      (ctl),
        .load_val_i (ld_val),
        .step_i     (off_q),
        .fire_o     (fire)
    );

    lcg_pin_drv pin_i (
        .clk    (clk),
        .rst    (rst),
        .idle_i (idle_i),
        .op_i   (op),
        .pin_o  (pin_o)
    );

    // R9
    halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (pin_o == $past(idle_i)) && (st_q == ST_IDLE));

    // R5
    link_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && link_i && !mode_i[1] && !go_i) |=> (st_q == ST_IDLE));

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !halt_i) |=> (st_q == ST_RUN));

    // R7
    run_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_RUN && !$past(halt_i) && pin_o != $past(pin_o)) |-> $past(fire));

    // R6
    off_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (off_q != '0));

endmodule

// File: tb/link_cmp_gen_tb_top.sv
module link_cmp_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tbase = '0;
    logic        go = 1'b0, halt = 1'b0, link = 1'b0;
    logic [1:0]  mode = '0, act = '0;
    logic        idle = 1'b1;
    logic [15:0] delay = '0, refv = '0, period = '0;
    logic [7:0]  ratio = '0;
    logic        pin;

    int          cyc = 0;
    logic [15:0] ofs = '0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tbase <= 16'(cyc) + ofs;

    link_cmp_gen #(.TW(16), .RW(8)) dut_i (
        .clk(clk), .rst(rst), .tbase_i(tbase), .go_i(go), .halt_i(halt),
        .link_i(link), .mode_i(mode), .act_i(act), .idle_i(idle),
        .delay_i(delay), .ref_i(refv), .period_i(period), .ratio_i(ratio),
        .pin_o(pin)
    );

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (pin !== exp) begin
            n_bad++;
            $display("FAIL %s: pin=%0b expected %0b at cycle %0d", tag, pin, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_halt(input logic lvl);
        idle = lvl;
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
    endtask

    function automatic logic fin_lvl(input logic [1:0] a, input logic lead);
        if (a == 2'd0) return 1'b1;
        if (a == 2'd1) return 1'b0;
        return ~lead;
    endfunction

    function automatic logic lead_lvl(input logic [1:0] a, input logic p0);
        if (a == 2'd0) return 1'b0;
        if (a == 2'd1) return 1'b1;
        return ~p0;
    endfunction

    task automatic imm_test(input logic [1:0] a, input int d, input string tag);
        int e, de;
        logic ld, fl;
        do_halt(1'b0);
        mode = 2'd0; act = a; delay = 16'(d);
        e = cyc + 1;
        go = 1'b1; @(negedge clk); go = 1'b0;
        de = (d == 0) ? 1 : d;
        ld = lead_lvl(a, 1'b0);
        fl = fin_lvl(a, ld);
        wait_cyc(e + de - 1); chk($sformatf("%s R2 lead a=%0d d=%0d", tag, a, d), ld);
        wait_cyc(e + de);     chk($sformatf("%s R2/R4 final a=%0d d=%0d", tag, a, d), fl);
        wait_cyc(e + de + 3); chk($sformatf("%s R2 hold a=%0d d=%0d", tag, a, d), fl);
    endtask

    task automatic dly_test(input logic [1:0] a, input int k, input int d, input string tag);
        int e;
        logic fl;
        do_halt(1'b0);
        mode = 2'd1; act = a; delay = 16'(d);
        refv = 16'(cyc) + ofs + 16'(k);
        e = cyc + 1;
        go = 1'b1; @(negedge clk); go = 1'b0;
        fl = fin_lvl(a, 1'b0);
        wait_cyc(e);             chk($sformatf("%s R3 no lead a=%0d", tag, a), 1'b0);
        wait_cyc(e + k + d - 1); chk($sformatf("%s R3 early a=%0d k=%0d d=%0d", tag, a, k, d), 1'b0);
        wait_cyc(e + k + d);     chk($sformatf("%s R3/R4 edge a=%0d k=%0d d=%0d", tag, a, k, d), fl);
        wait_cyc(e + k + d + 3); chk($sformatf("%s R3 hold a=%0d", tag, a), fl);
    endtask

    task automatic cont_test(input int p, input int r, input string tag);
        int e, off, f;
        do_halt(1'b0);
        mode = 2'd2; period = 16'(p); ratio = 8'(r); act = 2'd1;
        off = (p * r) >> 8;
        if (off == 0) off = 1;
        e = cyc + 1;
        link = 1'b1; @(negedge clk); link = 1'b0;
        f = e + 9 + off;
        wait_cyc(f - 1);       chk($sformatf("%s R7 latency p=%0d r=%0d", tag, p, r), 1'b0);
        wait_cyc(f);           chk($sformatf("%s R6/R7 first p=%0d r=%0d", tag, p, r), 1'b1);
        wait_cyc(f + off - 1); chk($sformatf("%s R6 high time p=%0d r=%0d", tag, p, r), 1'b1);
        wait_cyc(f + off);     chk($sformatf("%s R6/R7 fall p=%0d r=%0d", tag, p, r), 1'b0);
        wait_cyc(f + 2 * off); chk($sformatf("%s R7 rise p=%0d r=%0d", tag, p, r), 1'b1);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pl[5];
        int rl[6];
        int e, f, h;
        pl = '{3, 40, 100, 255, 1000};
        rl = '{0, 1, 64, 128, 200, 255};

        // R1: reset level follows idle
        repeat (3) @(negedge clk);
        chk("R1 reset idle=1", 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset idle=1", 1'b1);

        // R2, R4 sweep
        for (int a = 0; a < 4; a++) begin
            imm_test(2'(a), 0, "imm");
            imm_test(2'(a), 1, "imm");
            imm_test(2'(a), 2, "imm");
            imm_test(2'(a), 5, "imm");
            imm_test(2'(a), 13, "imm");
            imm_test(2'(a), 200, "imm");
        end

        // R3 sweep
        for (int a = 0; a < 3; a++) begin
            dly_test(2'(a), 1, 0, "dly");
            dly_test(2'(a), 1, 3, "dly");
            dly_test(2'(a), 4, 17, "dly");
        end

        // R6, R7 sweep
        foreach (pl[i]) begin
            foreach (rl[j]) begin
                cont_test(pl[i], rl[j], "cont");
            end
        end

        // R8: each mode across the time-base wrap
        ofs = 16'hFFF0 - 16'(cyc); @(negedge clk);
        imm_test(2'd0, 40, "R8 wrap");
        ofs = 16'hFFF0 - 16'(cyc); @(negedge clk);
        dly_test(2'd2, 2, 30, "R8 wrap");
        ofs = 16'hFFF0 - 16'(cyc); @(negedge clk);
        cont_test(100, 128, "R8 wrap");
        ofs = '0; @(negedge clk);

        // R5: go in continuous mode and link in one-shot modes do nothing
        do_halt(1'b0);
        mode = 2'd2; period = 16'd40; ratio = 8'd128;
        go = 1'b1; @(negedge clk); go = 1'b0;
        wait_cyc(cyc + 30); chk("R5 go ignored in continuous mode", 1'b0);
        mode = 2'd0; act = 2'd0; delay = 16'd4;
        link = 1'b1; @(negedge clk); link = 1'b0;
        wait_cyc(cyc + 30); chk("R5 link ignored in immediate mode", 1'b0);
        mode = 2'd1; refv = 16'(cyc) + 16'd3;
        link = 1'b1; @(negedge clk); link = 1'b0;
        wait_cyc(cyc + 30); chk("R5 link ignored in delayed mode", 1'b0);
        mode = 2'd0; act = 2'd1; delay = 16'd4;
        e = cyc + 1;
        go = 1'b1; @(negedge clk); go = 1'b0;
        wait_cyc(e + 3); chk("R5 channel still idle: lead", 1'b1);
        wait_cyc(e + 4); chk("R5 channel still idle: final", 1'b0);

        // R10: strobes ignored while running
        do_halt(1'b0);
        mode = 2'd2; period = 16'd40; ratio = 8'd128;
        e = cyc + 1;
        link = 1'b1; @(negedge clk); link = 1'b0;
        f = e + 9 + 20;
        wait_cyc(f + 5);
        mode = 2'd0; act = 2'd1; delay = 16'd3;
        go = 1'b1; @(negedge clk); go = 1'b0;
        mode = 2'd2; period = 16'd200;
        link = 1'b1; @(negedge clk); link = 1'b0;
        wait_cyc(f + 19); chk("R10 busy: still high", 1'b1);
        wait_cyc(f + 20); chk("R10 busy: fall on schedule", 1'b0);
        wait_cyc(f + 40); chk("R10 busy: rise on schedule", 1'b1);

        // R9: halt while running
        wait_cyc(f + 43);
        h = cyc + 1;
        do_halt(1'b0);
        chk("R9 halt drives idle low", 1'b0);
        wait_cyc(h + 22); chk("R9 no edge after halt", 1'b0);
        wait_cyc(h + 42); chk("R9 no edge after halt later", 1'b0);
        do_halt(1'b1);
        chk("R9 halt drives idle high", 1'b1);

        // R9: halt wins over go at the same edge
        do_halt(1'b0);
        mode = 2'd0; act = 2'd0; delay = 16'd3;
        e = cyc + 1;
        go = 1'b1; halt = 1'b1; @(negedge clk); go = 1'b0; halt = 1'b0;
        wait_cyc(e + 3); chk("R9 halt beats go", 1'b0);
        wait_cyc(e + 6); chk("R9 halt beats go later", 1'b0);

        // R9: halt cancels a pending one-shot
        mode = 2'd0; act = 2'd1; delay = 16'd10;
        e = cyc + 1;
        go = 1'b1; @(negedge clk); go = 1'b0;
        wait_cyc(e + 4);
        do_halt(1'b1);
        wait_cyc(e + 10); chk("R9 pending match cancelled", 1'b1);
        wait_cyc(e + 14); chk("R9 pending match cancelled later", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule